// File: doc/BRIEF.md
# Dual-Bus Address Break Comparator

This block watches one of two auxiliary data-memory buses, X or Y, and raises a break event when a cycle on the watched bus meets a programmed condition. Software programs it through a simple register port. The port holds a control word and one reference/mask address pair per bus. The control word sets four things: whether the comparator is armed, which bus it watches, the direction qualifier and the operand-size qualifier.

Each bus has its own window stage. A window stage compares the cycle address against its bus's reference under the mask and qualifies the cycle. Only the selected stage can trigger a break. The result is registered into a one-clock pulse, `brk_pulse`. At the same edge a sticky flag, `brk_flag`, is set and stays set until software writes 1 to clear it. With every register at its reset value of zero, the comparator is disarmed.

Top module: `xy_break_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and both `brk_pulse` and `brk_flag` are 0.
- R2: Register index 0 is control, 1 is X reference, 2 is X mask, 3 is Y reference, 4 is Y mask and 5 is status. Writes are captured at the clock edge. Reads are combinational. Control reads back only bits 4:0, status reads back only bit 0, and unmapped indices read zero.
- R3: Control bit 0 arms the comparator. While it is 0, no break is ever produced.
- R4: Control bit 1 selects the watched bus (0 = X, 1 = Y). Cycles on the other bus never produce a break.
- R5: X cycles are compared against the X reference and X mask (indices 1 and 2). Y cycles are compared against the Y reference and Y mask (indices 3 and 4).
- R6: An address matches when `((addr ^ ref) & ~mask) == 0`. A mask bit of 1 removes that bit from the compare.
- R7: A cycle qualifies only when valid is 1, the CPU is the master (`*_cpu` = 1) and the cycle is a data access (`*_data` = 1).
- R8: Control bits 3:2 are the direction qualifier. Bit 2 permits reads (`*_write` = 0) and bit 3 permits writes. 00 never matches, 01 matches reads, 10 matches writes and 11 matches either.
- R9: Control bit 4 = 1 requires a word-sized cycle (`*_word` = 1). Control bit 4 = 0 ignores the size.
- R10: `brk_pulse` is high in the clock cycle after each qualifying bus cycle and low otherwise.
- R11: `brk_flag` (status bit 0) is set together with `brk_pulse`. Writing 1 to status bit 0 clears it, and writing 0 leaves it set. A new match in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write index |
| reg_wdata | input | 16 | Register write data |
| reg_raddr | input | 3 | Register read index |
| reg_rdata | output | 16 | Register read data |
| x_valid | input | 1 | X bus cycle present |
| x_cpu | input | 1 | X cycle mastered by CPU |
| x_data | input | 1 | X cycle is a data access |
| x_write | input | 1 | X cycle is a write |
| x_word | input | 1 | X cycle is word sized |
| x_addr | input | 16 | X bus address |
| y_valid | input | 1 | Y bus cycle present |
| y_cpu | input | 1 | Y cycle mastered by CPU |
| y_data | input | 1 | Y cycle is a data access |
| y_write | input | 1 | Y cycle is a write |
| y_word | input | 1 | Y cycle is word sized |
| y_addr | input | 16 | Y bus address |
| brk_pulse | output | 1 | One-clock break pulse |
| brk_flag | output | 1 | Sticky break flag |

## Verification
The bench builds the block with its default parameters: 16-bit addresses and registers and a 3-bit register index. At this width, hand-picked addresses can place a single differing bit on either side of a mask boundary. The same width makes all-ones masks and full 16-bit readback easy to check. The 3-bit index reaches the unused indices 6 and 7, so the bench can confirm that they read back zero.

// File: rtl/xyb_pkg.sv
// Package: shared control and bus-cycle types for the dual-bus break
// comparator. Assumes register indices fit in the top's index width.
package xyb_pkg;

    // Control word fields, packed in readback bit order (bit 0 = en).
    typedef struct packed {
        logic       word_only;
        logic [1:0] rw;
        logic       sel;
        logic       en;
    } xyb_cfg_t;

    // Per-bus cycle qualifiers.
    typedef struct packed {
        logic valid;
        logic cpu;
        logic data;
        logic write;
        logic word;
    } xyb_cyc_t;

    localparam int CFG_BITS = $bits(xyb_cfg_t);

    localparam int IDX_CTRL   = 0;
    localparam int IDX_XREF   = 1;
    localparam int IDX_XMASK  = 2;
    localparam int IDX_YREF   = 3;
    localparam int IDX_YMASK  = 4;
    localparam int IDX_STATUS = 5;

endpackage

// File: rtl/xyb_regs.sv
// Module: register file of the break comparator. Holds the control word,
// one reference/mask pair per bus (entry 0 = X, 1 = Y) and the sticky
// flag. Assumes AW >= CFG_BITS. Writes land on the clock edge; reads are
// combinational. A new hit outranks a simultaneous write-1-to-clear.
module xyb_regs
    import xyb_pkg::*;
#(
    parameter int AW   = 16,
    parameter int RA_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RA_W-1:0]      wr_idx,
    input  logic [AW-1:0]        wr_data,
    input  logic [RA_W-1:0]      rd_idx,
    output logic [AW-1:0]        rd_data,
    input  logic                 hit_set,
    output xyb_cfg_t             cfg,
    output logic [1:0][AW-1:0]   ref_v,
    output logic [1:0][AW-1:0]   mask_v,
    output logic                 sticky
);

    logic clr_req;

    // Decode a write-1-to-clear on the status register.
    always_comb begin
        clr_req = wr_en && (wr_idx == RA_W'(IDX_STATUS)) && wr_data[0];
    end

    // Capture control and address registers from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg    <= '0;
            ref_v  <= '0;
            mask_v <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                RA_W'(IDX_CTRL):  cfg       <= xyb_cfg_t'(wr_data[CFG_BITS-1:0]);
                RA_W'(IDX_XREF):  ref_v[0]  <= wr_data;
                RA_W'(IDX_XMASK): mask_v[0] <= wr_data;
                RA_W'(IDX_YREF):  ref_v[1]  <= wr_data;
                RA_W'(IDX_YMASK): mask_v[1] <= wr_data;
                default: ;
            endcase
        end
    end

    // Sticky flag: set by a hit, cleared by write-1, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sticky <= 1'b0;
        else if (hit_set)
            sticky <= 1'b1;
        else if (clr_req)
            sticky <= 1'b0;
    end

    // Combinational readback mux.
    always_comb begin
        case (rd_idx)
            RA_W'(IDX_CTRL):   rd_data = AW'(cfg);
            RA_W'(IDX_XREF):   rd_data = ref_v[0];
            RA_W'(IDX_XMASK):  rd_data = mask_v[0];
            RA_W'(IDX_YREF):   rd_data = ref_v[1];
            RA_W'(IDX_YMASK):  rd_data = mask_v[1];
            RA_W'(IDX_STATUS): rd_data = AW'(sticky);
            default:           rd_data = '0;
        endcase
    end

endmodule

// File: rtl/xyb_window.sv
// Module: one bus window. Applies the masked address compare and the cycle
// qualifiers (valid, CPU master, data access, direction, size) to a single
// bus. Purely combinational; assumes the caller registers the result.
module xyb_window
    import xyb_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ref_a,
    input  logic [AW-1:0] mask_a,
    input  xyb_cyc_t      cyc,
    input  xyb_cfg_t      cfg,
    output logic          hit
);

    logic addr_ok;
    logic dir_ok;
    logic size_ok;

    // Address, direction and size checks, then the combined hit.
    always_comb begin
        addr_ok = (((addr ^ ref_a) & ~mask_a) == '0);
        dir_ok  = cyc.write ? cfg.rw[1] : cfg.rw[0];
        size_ok = !cfg.word_only || cyc.word;
        hit     = cyc.valid && cyc.cpu && cyc.data && dir_ok && size_ok && addr_ok;
    end

endmodule

// File: rtl/xyb_pick.sv
// Module: chooses the window of the selected bus, gates it with the arm
// bit and registers the break pulse. Also exposes the pre-register hit so
// the sticky flag sets on the same edge as the pulse.
module xyb_pick
    import xyb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  xyb_cfg_t   cfg,
    input  logic [1:0] win_hit,
    output logic       hit_now,
    output logic       pulse
);

    // Select the watched bus and apply the arm bit.
    always_comb begin
        hit_now = cfg.en && win_hit[cfg.sel];
    end

    // Register the break pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse <= 1'b0;
        else
            pulse <= hit_now;
    end

endmodule

// File: rtl/xy_break_unit.sv
// Module: top of the dual-bus address break comparator. Gathers the two
// buses into arrays and builds one window per bus with generate. The
// selected window drives a registered pulse and a sticky flag. Assumes
// synchronous active-low reset and AW >= 5.
module xy_break_unit
    import xyb_pkg::*;
#(
    parameter int AW   = 16,
    parameter int RA_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_waddr,
    input  logic [AW-1:0]   reg_wdata,
    input  logic [RA_W-1:0] reg_raddr,
    output logic [AW-1:0]   reg_rdata,
    input  logic            x_valid,
    input  logic            x_cpu,
    input  logic            x_data,
    input  logic            x_write,
    input  logic            x_word,
    input  logic [AW-1:0]   x_addr,
    input  logic            y_valid,
    input  logic            y_cpu,
    input  logic            y_data,
    input  logic            y_write,
    input  logic            y_word,
    input  logic [AW-1:0]   y_addr,
    output logic            brk_pulse,
    output logic            brk_flag
);

    localparam int NBUS = 2;

    xyb_cfg_t                cfg;
    logic [NBUS-1:0][AW-1:0] ref_v;
    logic [NBUS-1:0][AW-1:0] mask_v;
    logic [NBUS-1:0][AW-1:0] bus_addr;
    xyb_cyc_t [NBUS-1:0]     bus_cyc;
    logic [NBUS-1:0]         win_hit;
    logic                    hit_now;

    // Flat views of the control word for the bound checker.
    logic       cfg_en;
    logic       cfg_sel;
    logic [1:0] cfg_rw;

    // Gather both buses into indexable arrays (0 = X, 1 = Y).
    always_comb begin
        bus_addr[0] = x_addr;
        bus_addr[1] = y_addr;
        bus_cyc[0]  = '{valid: x_valid, cpu: x_cpu, data: x_data, write: x_write, word: x_word};
        bus_cyc[1]  = '{valid: y_valid, cpu: y_cpu, data: y_data, write: y_write, word: y_word};
        cfg_en      = cfg.en;
        cfg_sel     = cfg.sel;
        cfg_rw      = cfg.rw;
    end

    xyb_regs #(.AW(AW), .RA_W(RA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_idx  (reg_waddr),
        .wr_data (reg_wdata),
        .rd_idx  (reg_raddr),
        .rd_data (reg_rdata),
        .hit_set (hit_now),
        .cfg     (cfg),
        .ref_v   (ref_v),
        .mask_v  (mask_v),
        .sticky  (brk_flag)
    );

    for (genvar b = 0; b < NBUS; b++) begin : g_win
        xyb_window #(.AW(AW)) u_win (
            .addr   (bus_addr[b]),
            .ref_a  (ref_v[b]),
            .mask_a (mask_v[b]),
            .cyc    (bus_cyc[b]),
            .cfg    (cfg),
            .hit    (win_hit[b])
        );
    end

    xyb_pick u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .win_hit (win_hit),
        .hit_now (hit_now),
        .pulse   (brk_pulse)
    );

endmodule

// File: rtl/xyb_checker.sv
// Module: temporal checks on the break comparator, bound to its top.
// Looks at ports and the flattened control word only.
module xyb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_en,
    input logic       cfg_sel,
    input logic [1:0] cfg_rw,
    input logic       x_valid,
    input logic       x_cpu,
    input logic       x_data,
    input logic       y_valid,
    input logic       y_cpu,
    input logic       y_data,
    input logic       brk_pulse,
    input logic       brk_flag
);

    // A pulse needs the comparator armed in the previous cycle.
    assert_pulse_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> $past(cfg_en));

    // A pulse needs a valid CPU data cycle on the bus selected last cycle.
    assert_pulse_from_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> $past(cfg_sel ? (y_valid && y_cpu && y_data)
                                    : (x_valid && x_cpu && x_data)));

    // A pulse needs a CPU data access on the watched bus.
    assert_cpu_data_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> $past(cfg_sel ? y_cpu : x_cpu) && $past(cfg_sel ? y_data : x_data));

    // Direction qualifier 00 never matches.
    assert_rw_none_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rw == 2'b00) |=> !brk_pulse);

    // The flag is set whenever a pulse appears.
    assert_flag_with_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> brk_flag);

    // The flag only rises together with a pulse.
    assert_flag_rise_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> brk_pulse);

endmodule

bind xy_break_unit xyb_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_sel   (cfg_sel),
    .cfg_rw    (cfg_rw),
    .x_valid   (x_valid),
    .x_cpu     (x_cpu),
    .x_data    (x_data),
    .y_valid   (y_valid),
    .y_cpu     (y_cpu),
    .y_data    (y_data),
    .brk_pulse (brk_pulse),
    .brk_flag  (brk_flag)
);

// File: tb/sim_xy_break_unit.sv
module sim_xy_break_unit;

    localparam int AW = 16;
    localparam int RA_W = 3;
    localparam int NVEC = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [RA_W-1:0] reg_waddr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [RA_W-1:0] reg_raddr = '0;
    logic [AW-1:0] reg_rdata;
    logic x_valid = 0, x_cpu = 0, x_data = 0, x_write = 0, x_word = 0;
    logic y_valid = 0, y_cpu = 0, y_data = 0, y_write = 0, y_word = 0;
    logic [AW-1:0] x_addr = '0, y_addr = '0;
    logic brk_pulse, brk_flag;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xy_break_unit #(.AW(AW), .RA_W(RA_W)) u0 (.*);

    // Vector fields: ctrl[59:54] ref[53:38] mask[37:22]
    // {valid,cpu,data,write,word}[21:17] addr[16:1] expected pulse[0]
    // ctrl: bit0 arm, bit1 bus (1=Y), bit2 read ok, bit3 write ok, bit4 word only
    localparam logic [59:0] VEC [NVEC] = '{
        {6'h05, 16'h1234, 16'h0000, 5'b11100, 16'h1234, 1'b1}, // R5 R6 exact X read
        {6'h05, 16'h1234, 16'h0000, 5'b11100, 16'h1235, 1'b0}, // R6 one bit differs
        {6'h05, 16'h1230, 16'h000F, 5'b11100, 16'h123B, 1'b1}, // R6 masked low nibble
        {6'h05, 16'h1230, 16'h000F, 5'b11100, 16'h1330, 1'b0}, // R6 unmasked bit differs
        {6'h04, 16'h1234, 16'h0000, 5'b11100, 16'h1234, 1'b0}, // R3 not armed
        {6'h01, 16'h1234, 16'h0000, 5'b11100, 16'h1234, 1'b0}, // R8 qualifier none
        {6'h05, 16'h1234, 16'h0000, 5'b11110, 16'h1234, 1'b0}, // R8 write vs read-only
        {6'h0D, 16'h1234, 16'h0000, 5'b11110, 16'h1234, 1'b1}, // R8 either, write
        {6'h1B, 16'hABCD, 16'h0000, 5'b11111, 16'hABCD, 1'b1}, // R9 Y write word
        {6'h1B, 16'hABCD, 16'h0000, 5'b11110, 16'hABCD, 1'b0}, // R9 Y not word
        {6'h0B, 16'hABCD, 16'h0000, 5'b11110, 16'hABCD, 1'b1}, // R9 size ignored
        {6'h05, 16'h1234, 16'h0000, 5'b10100, 16'h1234, 1'b0}, // R7 not CPU master
        {6'h05, 16'h1234, 16'h0000, 5'b11000, 16'h1234, 1'b0}, // R7 not data access
        {6'h07, 16'h0000, 16'hFFFF, 5'b11100, 16'h5A5A, 1'b1}  // R5 R6 Y full mask
    };

    task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called at a negedge; write takes effect at the next posedge.
    task automatic wr(input int idx, input logic [AW-1:0] d);
        reg_we = 1'b1;
        reg_waddr = RA_W'(idx);
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input int idx, input logic [AW-1:0] exp);
        reg_raddr = RA_W'(idx);
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic idle_bus();
        {x_valid, x_cpu, x_data, x_write, x_word} = '0;
        {y_valid, y_cpu, y_data, y_write, y_word} = '0;
    endtask

    task automatic drive(input logic sel, input logic [4:0] q, input logic [AW-1:0] a);
        idle_bus();
        if (sel) begin
            {y_valid, y_cpu, y_data, y_write, y_word} = q;
            y_addr = a;
        end else begin
            {x_valid, x_cpu, x_data, x_write, x_word} = q;
            x_addr = a;
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 6; i++) rd_check("R1 reg reset", i, '0);
        check("R1 pulse reset", AW'(brk_pulse), '0);
        check("R1 flag reset", AW'(brk_flag), '0);

        // R2: register readback and unmapped indices
        wr(0, 16'hFFFF);
        rd_check("R2 ctrl width", 0, 16'h001F);
        wr(1, 16'h1111); wr(2, 16'h2222); wr(3, 16'h3333); wr(4, 16'h4444);
        rd_check("R2 xref", 1, 16'h1111);
        rd_check("R2 xmask", 2, 16'h2222);
        rd_check("R2 yref", 3, 16'h3333);
        rd_check("R2 ymask", 4, 16'h4444);
        rd_check("R2 unmapped 6", 6, '0);
        rd_check("R2 unmapped 7", 7, '0);
        wr(0, 16'h0000);

        // Table walk: program, drive one cycle, check pulse next cycle and after.
        for (int v = 0; v < NVEC; v++) begin
            logic [5:0] c;
            logic sel;
            c = VEC[v][59:54];
            sel = c[1];
            wr(0, AW'(c));
            wr(sel ? 3 : 1, VEC[v][53:38]);
            wr(sel ? 4 : 2, VEC[v][37:22]);
            wr(sel ? 1 : 3, ~VEC[v][53:38]);
            wr(sel ? 2 : 4, 16'h0000);
            drive(sel, VEC[v][21:17], VEC[v][16:1]);
            @(negedge clk);
            check($sformatf("R10 vec %0d pulse (R3 R5 R6 R7 R8 R9)", v),
                  AW'(brk_pulse), AW'(VEC[v][0]));
            idle_bus();
            @(negedge clk);
            check($sformatf("R10 vec %0d pulse ends", v), AW'(brk_pulse), '0);
        end

        // R4/R5: other bus ignored; each bus uses its own pair.
        wr(5, 16'h0001);
        wr(0, 16'h000D);               // armed, X, either direction
        wr(1, 16'h1111); wr(2, 16'h0000);
        wr(3, 16'h2222); wr(4, 16'h0000);
        drive(1'b1, 5'b11100, 16'h1111); // Y cycle hitting X pair
        @(negedge clk);
        check("R4 unselected Y ignored", AW'(brk_pulse), '0);
        drive(1'b0, 5'b11100, 16'h2222); // X cycle at Y reference
        @(negedge clk);
        check("R5 X uses X pair", AW'(brk_pulse), '0);
        wr(0, 16'h000F);               // select Y
        drive(1'b0, 5'b11100, 16'h2222); // X cycle while Y selected
        @(negedge clk);
        check("R4 unselected X ignored", AW'(brk_pulse), '0);
        drive(1'b1, 5'b11100, 16'h2222);
        @(negedge clk);
        check("R5 Y uses Y pair", AW'(brk_pulse), 16'h0001);
        idle_bus();
        @(negedge clk);

        // R11: sticky behaviour
        check("R11 flag held", AW'(brk_flag), 16'h0001);
        wr(5, 16'h0000);
        rd_check("R11 write 0 keeps", 5, 16'h0001);
        wr(5, 16'h0001);
        rd_check("R11 write 1 clears", 5, 16'h0000);
        drive(1'b1, 5'b11100, 16'h2222);
        wr(5, 16'h0001);               // match and clear in same cycle
        idle_bus();
        check("R11 set beats clear", AW'(brk_flag), 16'h0001);
        wr(5, 16'h0001);
        check("R11 cleared after", AW'(brk_flag), '0);

        // R10: held qualifying cycle pulses every cycle
        drive(1'b1, 5'b11100, 16'h2222);
        @(negedge clk);
        @(negedge clk);
        check("R10 back-to-back", AW'(brk_pulse), 16'h0001);
        idle_bus();
        @(negedge clk);
        check("R10 drops", AW'(brk_pulse), '0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule